// File: doc/BRIEF.md
# Streaming 2x2 Max-Pool Unit

This unit reduces a signed fixed-point feature map (32-bit, 16 fractional bits) by a factor of two in each direction. It keeps the largest value of every non-overlapping 2x2 window. Pixels enter one at a time in row-major order through a ready/valid input. Pooled results leave through a ready/valid output, also in row-major order. With the default 26x26 input, the unit produces a 13x13 result map. Either side of the unit can stall it.

The first row of each window pair goes into a small line buffer as packed pairs. On the second row, the left pixel is held in a register. When the right pixel arrives, the window is complete. The maximum is then found by a fixed chain of three signed compare-and-select steps, in the order top-left, top-right, bottom-left, bottom-right. The result is registered into the output.

A parameter selects between two variants:
- **Stream-only:** the result map is not stored at all, and the read-back port returns zero.
- **Stored:** every result is also written into an on-chip map, which a downstream stage can read by index.

When the last result has been accepted downstream, the unit raises a sticky completion flag. It then takes no further input until reset.

Top module: `maxpool2x2_stream`

## Requirements
- R1: Each result equals the signed maximum of its four window pixels, compared as two's-complement values; this holds for the extremes 0x80000000 and 0x7FFFFFFF.
- R2: Results appear in row-major order of the output grid; a 26x26 input yields exactly 169 results, window (r,c) covering input rows 2r..2r+1 and columns 2c..2c+1.
- R3: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R4: While out_valid is high and out_ready is low, in_ready is low, so no new window can be committed.
- R5: The result of a window becomes valid in the cycle right after its bottom-right pixel is accepted; with out_ready held high and input arriving every cycle, one result is delivered per completed window with no added wait.
- R6: done stays low until the last result has been accepted, then goes high and stays high; while done is high, in_ready is low.
- R7: During and right after reset, out_valid and done are low and in_ready is high.
- R8: With STREAM_ONLY=0, reading rd_addr = r*13+c after completion returns the result of window (r,c); with STREAM_ONLY=1, rd_data is always zero and the streamed results are identical to those of the stored variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Unit accepts the input pixel this cycle |
| in_data | input | DW (32) | Input pixel, signed fixed-point |
| out_valid | output | 1 | Pooled result present |
| out_ready | input | 1 | Downstream accepts the result this cycle |
| out_data | output | DW (32) | Pooled result, signed fixed-point |
| done | output | 1 | Sticky flag: whole map pooled and delivered |
| rd_addr | input | AW (8) | Read index into stored result map, row-major |
| rd_data | output | DW (32) | Stored result at rd_addr (zero in stream-only variant) |

## Verification
The result of a window is registered, so it appears one cycle after the bottom-right pixel is accepted. The driver records the cycle in which it presents that pixel with in_ready high. The monitor samples at the falling edge and checks that the pop happens exactly one cycle later whenever out_ready is held high.

Under random backpressure, the monitor checks the hold rule at each falling edge by comparing against the value from the previous cycle. The done flag is checked twice:
- low at the falling edge before the last handshake;
- high at the falling edge after it.

The stored map is read through the combinational read port once the frame is complete.

// File: rtl/mp_pool_pkg.sv
package mp_pool_pkg;
   // which half of a window pair a row or column belongs to
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } pair_phase_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = (v <= 1) ? 1 : $clog2(v);
      return r;
   endfunction
endpackage

// File: rtl/mp_linebuf.sv
module mp_linebuf #(
   parameter int DW    = 32,
   parameter int DEPTH = 13,
   parameter int AW    = 4
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_idx,
   input  logic [DW-1:0]   wr_left,
   input  logic [DW-1:0]   wr_right,
   input  logic [AW-1:0]   rd_idx,
   output logic [DW-1:0]   rd_left,
   output logic [DW-1:0]   rd_right
);
   logic [2*DW-1:0] pair_mem [DEPTH];
   logic [2*DW-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_idx) < DEPTH))
         pair_mem[wr_idx] <= {wr_right, wr_left};
   end

   always_comb begin
      if (int'(rd_idx) < DEPTH)
         rd_word = pair_mem[rd_idx];
      else
         rd_word = '0;
   end

   assign rd_left  = rd_word[DW-1:0];
   assign rd_right = rd_word[2*DW-1:DW];
endmodule

// File: rtl/mp_cmp3.sv
module mp_cmp3 #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] tl,
   input  logic [DW-1:0] tr,
   input  logic [DW-1:0] bl,
   input  logic [DW-1:0] br,
   output logic [DW-1:0] maxv
);
   localparam int NSTEP = 3;

   logic [DW-1:0] cand  [NSTEP];
   logic [DW-1:0] stage [NSTEP+1];

   assign cand[0]  = tr;
   assign cand[1]  = bl;
   assign cand[2]  = br;
   assign stage[0] = tl;

   // three compare-and-select steps, one after another
   for (genvar s = 0; s < NSTEP; s++) begin : g_step
      always_comb begin
         if ($signed(cand[s]) > $signed(stage[s]))
            stage[s+1] = cand[s];
         else
            stage[s+1] = stage[s];
      end
   end

   assign maxv = stage[NSTEP];
endmodule

// File: rtl/mp_store.sv
module mp_store #(
   parameter int DW          = 32,
   parameter int DEPTH       = 169,
   parameter int AW          = 8,
   parameter bit STREAM_ONLY = 1'b0
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [DW-1:0]   rd_data
);
   if (STREAM_ONLY) begin : g_none
      logic unused_ok;
      assign unused_ok = ^{clk, wr_en, wr_addr, wr_data, rd_addr};
      assign rd_data   = '0;
   end else begin : g_map
      logic [DW-1:0] map_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_addr) < DEPTH))
            map_mem[wr_addr] <= wr_data;
      end

      always_comb begin
         if (int'(rd_addr) < DEPTH)
            rd_data = map_mem[rd_addr];
         else
            rd_data = '0;
      end
   end
endmodule

// File: rtl/maxpool2x2_stream.sv
module maxpool2x2_stream
   import mp_pool_pkg::*;
#(
   parameter int DW          = 32,
   parameter int IN_W        = 26,
   parameter int IN_H        = 26,
   parameter bit STREAM_ONLY = 1'b0,
   parameter int AW          = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [DW-1:0]   in_data,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [DW-1:0]   out_data,
   output logic            done,
   input  logic [AW-1:0]   rd_addr,
   output logic [DW-1:0]   rd_data
);
   localparam int OUT_W = IN_W / 2;
   localparam int OUT_H = IN_H / 2;
   localparam int OUT_N = OUT_W * OUT_H;
   localparam int CW    = clog2_min1(IN_W);
   localparam int RW    = clog2_min1(IN_H);
   localparam int OWW   = clog2_min1(OUT_W);
   localparam int NW    = clog2_min1(OUT_N + 1);

   initial begin
      if (IN_W < 2 || (IN_W % 2) != 0)
         $error("IN_W must be even and at least 2");
      if (IN_H < 2 || (IN_H % 2) != 0)
         $error("IN_H must be even and at least 2");
      if (DW < 2)
         $error("DW must be at least 2");
      if ((1 << AW) < OUT_N)
         $error("AW too narrow for the result map");
   end

   logic [CW-1:0]  col_q;
   logic [RW-1:0]  row_q;
   logic           in_done_q;
   logic [DW-1:0]  hold_q;
   logic [NW-1:0]  res_cnt_q;
   logic [AW-1:0]  wr_idx_q;
   logic           done_q;
   logic           oval_q;
   logic [DW-1:0]  odat_q;

   pair_phase_e    row_ph, col_ph;
   logic           stall;
   logic           in_fire, out_fire, win_fire, lb_wr;
   logic           last_col, last_row;
   logic [OWW-1:0] win_col;
   logic [DW-1:0]  lb_left, lb_right, win_max;

   assign row_ph   = pair_phase_e'(row_q[0]);
   assign col_ph   = pair_phase_e'(col_q[0]);
   assign win_col  = OWW'(col_q >> 1);
   assign last_col = (col_q == CW'(IN_W - 1));
   assign last_row = (row_q == RW'(IN_H - 1));

   assign stall    = oval_q && !out_ready;
   assign in_ready = !in_done_q && !done_q && !stall;
   assign in_fire  = in_valid && in_ready;
   assign out_fire = oval_q && out_ready;
   assign lb_wr    = in_fire && (row_ph == PH_FIRST)  && (col_ph == PH_SECOND);
   assign win_fire = in_fire && (row_ph == PH_SECOND) && (col_ph == PH_SECOND);

   // scan position of the incoming pixel
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q     <= '0;
         row_q     <= '0;
         in_done_q <= 1'b0;
      end else if (in_fire) begin
         if (last_col) begin
            col_q <= '0;
            if (last_row) begin
               row_q     <= '0;
               in_done_q <= 1'b1;
            end else begin
               row_q <= row_q + RW'(1);
            end
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end

   // left pixel of the current pair (top-left on first row, bottom-left on second)
   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (in_fire && (col_ph == PH_FIRST))
         hold_q <= in_data;
   end

   mp_linebuf #(
      .DW    (DW),
      .DEPTH (OUT_W),
      .AW    (OWW)
   ) u_linebuf (
      .clk      (clk),
      .wr_en    (lb_wr),
      .wr_idx   (win_col),
      .wr_left  (hold_q),
      .wr_right (in_data),
      .rd_idx   (win_col),
      .rd_left  (lb_left),
      .rd_right (lb_right)
   );

   mp_cmp3 #(
      .DW (DW)
   ) u_cmp3 (
      .tl   (lb_left),
      .tr   (lb_right),
      .bl   (hold_q),
      .br   (in_data),
      .maxv (win_max)
   );

   // single-entry output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oval_q <= 1'b0;
         odat_q <= '0;
      end else if (win_fire) begin
         oval_q <= 1'b1;
         odat_q <= win_max;
      end else if (out_fire) begin
         oval_q <= 1'b0;
      end
   end

   // delivered-result count and sticky completion
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_cnt_q <= '0;
         done_q    <= 1'b0;
      end else if (out_fire) begin
         res_cnt_q <= res_cnt_q + NW'(1);
         if (res_cnt_q == NW'(OUT_N - 1))
            done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wr_idx_q <= '0;
      else if (win_fire)
         wr_idx_q <= wr_idx_q + AW'(1);
   end

   mp_store #(
      .DW          (DW),
      .DEPTH       (OUT_N),
      .AW          (AW),
      .STREAM_ONLY (STREAM_ONLY)
   ) u_store (
      .clk     (clk),
      .wr_en   (win_fire),
      .wr_addr (wr_idx_q),
      .wr_data (win_max),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign out_valid = oval_q;
   assign out_data  = odat_q;
   assign done      = done_q;
endmodule

// File: rtl/maxpool2x2_stream_chk.sv
module maxpool2x2_stream_chk #(
   parameter int DW          = 32,
   parameter int AW          = 8,
   parameter bit STREAM_ONLY = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic          done,
   input logic          win_fire,
   input logic [DW-1:0] rd_data
);
   a_r3_hold_data : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("R3 result changed while stalled");

   a_r4_no_accept : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready)
      else $error("R4 input accepted while stalled");

   a_r5_next_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      win_fire |=> out_valid)
      else $error("R5 result not valid one cycle after window");

   a_r6_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done)
      else $error("R6 completion flag dropped");

   a_r6_closed : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready)
      else $error("R6 input open after completion");

   a_r7_reset : assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !done))
      else $error("R7 reset state wrong");

   always_comb begin
      if (STREAM_ONLY)
         a_r8_no_map : assert (rd_data == '0)
            else $error("R8 stream-only read not zero");
   end

   logic unused_in;
   assign unused_in = in_valid;
endmodule

bind maxpool2x2_stream maxpool2x2_stream_chk #(
   .DW          (DW),
   .AW          (AW),
   .STREAM_ONLY (STREAM_ONLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .done      (done),
   .win_fire  (win_fire),
   .rd_data   (rd_data)
);

// File: tb/maxpool2x2_stream_bench.sv
module maxpool2x2_stream_bench;
   localparam int DW    = 32;
   localparam int IW    = 26;
   localparam int IH    = 26;
   localparam int AW    = 8;
   localparam int OW    = IW / 2;
   localparam int OH    = IH / 2;
   localparam int ON    = OW * OH;

   typedef struct {
      logic [DW-1:0] val;
      int            cyc;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_ready = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic          in_ready, out_valid, done;
   logic [DW-1:0] out_data, rd_data;
   logic          so_in_ready, so_out_valid, so_done;
   logic [DW-1:0] so_out_data, so_rd_data;

   int   n_run = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   got = 0;
   bit   timed = 1'b0;
   bit   rmode = 1'b0;
   bit   gaps = 1'b0;
   bit   prev_stall = 1'b0;
   bit   finished = 1'b0;
   logic [DW-1:0] prev_data = '0;
   logic [DW-1:0] img [IH][IW];
   logic [DW-1:0] exp_map [ON];
   exp_t sb [$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   maxpool2x2_stream #(.DW(DW), .IN_W(IW), .IN_H(IH), .STREAM_ONLY(1'b0), .AW(AW))
   u_maxpool2x2_stream (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done(done), .rd_addr(rd_addr), .rd_data(rd_data));

   maxpool2x2_stream #(.DW(DW), .IN_W(IW), .IN_H(IH), .STREAM_ONLY(1'b1), .AW(AW))
   u_maxpool2x2_stream_so (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(so_in_ready),
      .in_data(in_data), .out_valid(so_out_valid), .out_ready(out_ready),
      .out_data(so_out_data), .done(so_done), .rd_addr(rd_addr), .rd_data(so_rd_data));

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [DW-1:0] smax(input logic [DW-1:0] a, input logic [DW-1:0] b);
      return ($signed(a) > $signed(b)) ? a : b;
   endfunction

   // compute expected map from the image, straight from the window definition
   task automatic build_expected();
      for (int r = 0; r < OH; r++)
         for (int c = 0; c < OW; c++)
            exp_map[r*OW+c] = smax(smax(img[2*r][2*c], img[2*r][2*c+1]),
                                   smax(img[2*r+1][2*c], img[2*r+1][2*c+1]));
   endtask

   // out_ready changes away from both edges
   always @(posedge clk) begin
      #1;
      out_ready <= rmode ? (($urandom % 3) != 0) : 1'b1;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            check(out_valid == 1'b1, "R3 valid held", {31'b0, out_valid}, 1);
            check(out_data == prev_data, "R3 data held", out_data, prev_data);
         end
         if (out_valid && !out_ready)
            check(in_ready == 1'b0, "R4 in_ready while stalled", {31'b0, in_ready}, 0);
         if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 unexpected extra result", out_data, '0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(out_data == e.val, "R1 R2 result value", out_data, e.val);
               if (timed)
                  check(cyc == e.cyc + 1, "R5 latency", cyc, e.cyc + 1);
               check(so_out_valid && so_out_data == out_data,
                     "R8 stream-only output matches", so_out_data, out_data);
               if (got == ON - 1)
                  check(done == 1'b0, "R6 done before last handshake", {31'b0, done}, 0);
               got++;
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end else begin
         prev_stall = 1'b0;
      end
   end

   task automatic drive_frame();
      for (int r = 0; r < IH; r++) begin
         for (int c = 0; c < IW; c++) begin
            @(negedge clk);
            if (gaps) begin
               while (($urandom % 4) == 0) begin
                  in_valid = 1'b0;
                  @(negedge clk);
               end
            end
            in_valid = 1'b1;
            in_data  = img[r][c];
            while (!in_ready) @(negedge clk);
            if ((r % 2 == 1) && (c % 2 == 1)) begin
               exp_t e;
               e.val = exp_map[(r/2)*OW + c/2];
               e.cyc = cyc;
               sb.push_back(e);
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic apply_reset();
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", {31'b0, out_valid}, 0);
      check(done == 1'b0, "R7 done in reset", {31'b0, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R7 in_ready after reset", {31'b0, in_ready}, 1);
      check(out_valid == 1'b0, "R7 out_valid after reset", {31'b0, out_valid}, 0);
      got = 0;
      sb.delete();
   endtask

   task automatic finish_frame();
      wait (got == ON);
      @(negedge clk);
      check(done == 1'b1, "R6 done after last result", {31'b0, done}, 1);
      check(in_ready == 1'b0, "R6 input closed after done", {31'b0, in_ready}, 0);
      check(got == ON, "R2 result count", got, ON);
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R6 extra input ignored", {31'b0, out_valid}, 0);
      check(done == 1'b1, "R6 done sticky", {31'b0, done}, 1);
      in_valid = 1'b0;
   endtask

   task automatic check_map();
      for (int i = 0; i < ON; i++) begin
         rd_addr = AW'(i);
         #1;
         check(rd_data == exp_map[i], "R8 stored map", rd_data, exp_map[i]);
         check(so_rd_data == '0, "R8 stream-only read zero", so_rd_data, '0);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      // frame A: structured signed values with extremes, full rate, timed
      for (int r = 0; r < IH; r++)
         for (int c = 0; c < IW; c++)
            img[r][c] = DW'(((r * 37 + c * 11) % 23) - 11) <<< 16;
      img[0][0] = 32'h8000_0000; img[0][1] = 32'h8000_0000;
      img[1][0] = 32'h8000_0000; img[1][1] = 32'h8000_0000;  // all most-negative (R1)
      img[IH-1][IW-1] = 32'h7FFF_FFFF;                       // most positive (R1)
      img[2][3] = 32'hFFFF_0000; img[2][2] = 32'hFFFE_0000;
      img[3][2] = 32'hFFFD_0000; img[3][3] = 32'hFFFC_0000;  // all negative window
      build_expected();
      timed = 1'b1; rmode = 1'b0; gaps = 1'b0;
      apply_reset();
      drive_frame();
      finish_frame();
      check_map();

      // frame B: random data, random gaps and backpressure
      for (int r = 0; r < IH; r++)
         for (int c = 0; c < IW; c++)
            img[r][c] = $urandom;
      build_expected();
      timed = 1'b0; rmode = 1'b1; gaps = 1'b1;
      apply_reset();
      drive_frame();
      finish_frame();
      rmode = 1'b0;
      check_map();

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", got, ON);
         summary();
         $finish;
      end
   end
endmodule